// File: doc/BRIEF.md
# Command Packet Decoder and Responder

This block sits behind a byte-serial transfer engine. It accepts one packet at a time as a byte stream. The first byte is the packet type. For command packets, the second byte is the command code and any further bytes are arguments. The block matches the command, checks that the argument count is correct, and runs the command against its own state. It then returns a response packet as a second byte stream.

The local state is:
- a 32-bit seconds counter measured from the start of 1904;
- a poll enable flag;
- a poll period in milliseconds;
- a 16-bit device poll mask.

These values drive an external poll scheduler through plain level outputs, plus a one-cycle pulse whenever the enable flag actually changes. The power-off and system-restart commands raise one-cycle request pulses for the chip's power controller. They also return a normal success reply.

Both data interfaces use valid/ready:
- A byte moves when valid and ready are both high at a clock edge. The last byte of a packet carries the last flag.
- While valid is high and ready is low, the sender must hold its byte and flag steady.
- The input side drops ready from the cycle after the last byte of a command packet is taken. Ready stays low until the last response byte has been taken.
- The consumer may throttle the response with ready for as long as it likes.

Top module: `cmd_responder`

## Requirements
- R1: Once a command packet's last byte is taken, in_ready stays low until the response's last byte is accepted. While out_valid is high and out_ready is low, out_data and out_last hold their values.
- R2: A command packet has type byte 0x01. The recognised command codes are 0x01 poll enable, 0x03 read time, 0x09 write time, 0x0A power-off, 0x11 system restart, 0x14 poll period and 0x19 poll mask. A success reply is 0x01, 0x00, the command code, then any result bytes.
- R3: The required argument counts are 1 for poll enable and poll period, 2 for poll mask, 4 for write time, and 0 for the others. A recognised command with any other count gets the four-byte reply 0x02, 0x05, 0x01, command code, and its effect is suppressed.
- R4: An unrecognised command code gets the four-byte reply 0x02, 0x02, 0x01, command code.
- R5: Read time replies with the seconds counter as four bytes, most significant first. After reset the counter holds UNIX_RESET + 2082844800. It advances by one every CLK_HZ clock cycles.
- R6: Write time loads its four argument bytes into the counter, first byte most significant, and restarts the one-second prescaler.
- R7: Poll period sets poll_period from its argument. An argument of zero is treated as a bad argument per R3, and poll_period keeps its value. poll_period resets to 20.
- R8: Poll mask sets poll_mask, with the first argument as the high byte. poll_mask resets to 0xFFFF.
- R9: Poll enable sets poll_en high for any nonzero argument and low for zero. poll_en resets low. poll_change pulses for one cycle only when poll_en takes a new value.
- R10: A correctly formed power-off or system-restart command pulses pwr_off_req or sys_rst_req, respectively, for exactly one cycle.
- R11: The block consumes packets whose type is not 0x01, and packets of fewer than two bytes, without a reply and without any state change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| in_valid | input | 1 | Packet byte offered |
| in_ready | output | 1 | Block can take a packet byte |
| in_data | input | 8 | Packet byte |
| in_last | input | 1 | Final byte of the packet |
| out_valid | output | 1 | Response byte offered |
| out_ready | input | 1 | Consumer takes the response byte |
| out_data | output | 8 | Response byte |
| out_last | output | 1 | Final byte of the response |
| poll_en | output | 1 | Poll scheduler enable |
| poll_period | output | 8 | Poll period in milliseconds |
| poll_mask | output | 16 | Device poll mask |
| poll_change | output | 1 | One-cycle pulse when poll_en changes |
| pwr_off_req | output | 1 | One-cycle power-off request |
| sys_rst_req | output | 1 | One-cycle system restart request |

## Verification
The bench builds the block with CLK_HZ at 50 and UNIX_RESET at 1000, keeping MAX_ARGS at its default of 4. A 50-cycle second makes the counter roll over many times in one run, so read-time replies are checked at exact prescaler positions. That includes straight after a write-time reload. A nonzero reset value shows that the epoch offset is added to it rather than replacing it. With MAX_ARGS at 4, packets of five arguments reach the saturated argument count, which must still be reported as a bad count.

// File: rtl/cmd_responder_pkg.sv
package cmd_responder_pkg;
  localparam logic [7:0] PT_CMD      = 8'h01;
  localparam logic [7:0] PT_ERR      = 8'h02;
  localparam logic [7:0] ERR_BADARG  = 8'h05;
  localparam logic [7:0] ERR_UNKNOWN = 8'h02;
  localparam logic [31:0] EPOCH_SHIFT = 32'd2082844800;
  localparam logic [7:0] DEF_PERIOD  = 8'd20;
  localparam logic [15:0] DEF_MASK   = 16'hFFFF;
  localparam int TIME_BYTES = 4;

  typedef enum logic [7:0] {
    OP_AUTOPOLL  = 8'h01,
    OP_GET_TIME  = 8'h03,
    OP_SET_TIME  = 8'h09,
    OP_POWER_OFF = 8'h0A,
    OP_RESTART   = 8'h11,
    OP_POLL_RATE = 8'h14,
    OP_POLL_MASK = 8'h19
  } op_e;
endpackage

// File: rtl/cmdrsp_rx.sv
module cmdrsp_rx
  import cmd_responder_pkg::*;
#(
  parameter int MAX_ARGS = 4,
  localparam int IDX_MAX = MAX_ARGS + 2,
  localparam int IW = $clog2(IDX_MAX + 1),
  localparam int CW = $clog2(MAX_ARGS + 2)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  input  logic [7:0] in_data,
  input  logic in_last,
  input  logic hold,
  output logic in_ready,
  output logic pkt_valid,
  output logic [7:0] pkt_cmd,
  output logic [MAX_ARGS-1:0][7:0] pkt_args,
  output logic [CW-1:0] pkt_nargs
);
  logic [IW-1:0] idx;
  logic [7:0] ptype;
  logic fire;

  assign in_ready = !pkt_valid && !hold;
  assign fire = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      idx <= '0;
      ptype <= '0;
      pkt_cmd <= '0;
      pkt_nargs <= '0;
      pkt_valid <= 1'b0;
    end else begin
      pkt_valid <= 1'b0;
      if (fire) begin
        if (idx == IW'(0)) ptype <= in_data;
        if (idx == IW'(1)) pkt_cmd <= in_data;
        if (in_last) begin
          idx <= '0;
          pkt_valid <= (idx != IW'(0)) && (ptype == PT_CMD);
          pkt_nargs <= CW'(idx - IW'(1));
        end else if (idx < IW'(IDX_MAX)) begin
          idx <= idx + IW'(1);
        end
      end
    end
  end

  for (genvar k = 0; k < MAX_ARGS; k++) begin : g_arg
    always_ff @(posedge clk) begin
      if (rst) pkt_args[k] <= '0;
      else if (fire && idx == IW'(k + 2)) pkt_args[k] <= in_data;
    end
  end
endmodule

// File: rtl/cmdrsp_rtc.sv
module cmdrsp_rtc
  import cmd_responder_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter logic [31:0] UNIX_RESET = 32'd0,
  localparam int PW = (CLK_HZ > 1) ? $clog2(CLK_HZ) : 1
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic [31:0] load_val,
  output logic [31:0] seconds
);
  logic [PW-1:0] pre;

  always_ff @(posedge clk) begin
    if (rst) begin
      pre <= '0;
      seconds <= UNIX_RESET + EPOCH_SHIFT;
    end else if (load) begin
      pre <= '0;
      seconds <= load_val;
    end else if (pre == PW'(CLK_HZ - 1)) begin
      pre <= '0;
      seconds <= seconds + 32'd1;
    end else begin
      pre <= pre + PW'(1);
    end
  end
endmodule

// File: rtl/cmdrsp_exec.sv
module cmdrsp_exec
  import cmd_responder_pkg::*;
#(
  parameter int MAX_ARGS = 4,
  parameter int RESP_MAX = 7,
  localparam int CW = $clog2(MAX_ARGS + 2),
  localparam int LW = $clog2(RESP_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic go,
  input  logic [7:0] cmd,
  input  logic [MAX_ARGS-1:0][7:0] args,
  input  logic [CW-1:0] nargs,
  input  logic [31:0] seconds,
  output logic [RESP_MAX-1:0][7:0] frame,
  output logic [LW-1:0] frame_len,
  output logic time_load,
  output logic [31:0] time_val,
  output logic poll_en,
  output logic [7:0] poll_period,
  output logic [15:0] poll_mask,
  output logic poll_change,
  output logic pwr_off_req,
  output logic sys_rst_req
);
  logic bad, unk;
  logic do_en, do_rate, do_mask, do_off, do_rst, do_set, do_get;
  logic new_en;

  always_comb begin
    bad = 1'b0; unk = 1'b0;
    do_en = 1'b0; do_rate = 1'b0; do_mask = 1'b0; do_off = 1'b0;
    do_rst = 1'b0; do_set = 1'b0; do_get = 1'b0;
    case (cmd)
      OP_AUTOPOLL:  if (nargs == CW'(1)) do_en = 1'b1; else bad = 1'b1;
      OP_POLL_RATE: if (nargs == CW'(1) && args[0] != 8'd0) do_rate = 1'b1; else bad = 1'b1;
      OP_POLL_MASK: if (nargs == CW'(2)) do_mask = 1'b1; else bad = 1'b1;
      OP_POWER_OFF: if (nargs == CW'(0)) do_off = 1'b1; else bad = 1'b1;
      OP_RESTART:   if (nargs == CW'(0)) do_rst = 1'b1; else bad = 1'b1;
      OP_GET_TIME:  if (nargs == CW'(0)) do_get = 1'b1; else bad = 1'b1;
      OP_SET_TIME:  if (nargs == CW'(TIME_BYTES)) do_set = 1'b1; else bad = 1'b1;
      default:      unk = 1'b1;
    endcase
  end

  always_comb begin
    frame = '0;
    if (unk || bad) begin
      frame[0] = PT_ERR;
      frame[1] = unk ? ERR_UNKNOWN : ERR_BADARG;
      frame[2] = PT_CMD;
      frame[3] = cmd;
      frame_len = LW'(4);
    end else begin
      frame[0] = PT_CMD;
      frame[1] = 8'h00;
      frame[2] = cmd;
      frame_len = LW'(3);
      if (do_get) begin
        for (int b = 0; b < TIME_BYTES; b++)
          frame[3 + b] = seconds[8*(TIME_BYTES-1-b) +: 8];
        frame_len = LW'(3 + TIME_BYTES);
      end
    end
  end

  assign new_en = (args[0] != 8'd0);
  assign time_load = go && do_set;
  assign time_val = {args[0], args[1], args[2], args[3]};

  always_ff @(posedge clk) begin
    if (rst) begin
      poll_en <= 1'b0;
      poll_period <= DEF_PERIOD;
      poll_mask <= DEF_MASK;
      poll_change <= 1'b0;
      pwr_off_req <= 1'b0;
      sys_rst_req <= 1'b0;
    end else begin
      poll_change <= 1'b0;
      pwr_off_req <= go && do_off;
      sys_rst_req <= go && do_rst;
      if (go && do_en) begin
        poll_en <= new_en;
        poll_change <= (new_en != poll_en);
      end
      if (go && do_rate) poll_period <= args[0];
      if (go && do_mask) poll_mask <= {args[0], args[1]};
    end
  end
endmodule

// File: rtl/cmdrsp_tx.sv
module cmdrsp_tx #(
  parameter int RESP_MAX = 7,
  localparam int LW = $clog2(RESP_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic load,
  input  logic [RESP_MAX-1:0][7:0] frame_in,
  input  logic [LW-1:0] len_in,
  input  logic out_ready,
  output logic out_valid,
  output logic [7:0] out_data,
  output logic out_last
);
  logic [RESP_MAX-1:0][7:0] frm;
  logic [LW-1:0] len;
  logic [LW-1:0] idx;

  assign out_data = frm[idx];
  assign out_last = out_valid && (idx == len - LW'(1));

  always_ff @(posedge clk) begin
    if (rst) begin
      frm <= '0;
      len <= '0;
      idx <= '0;
      out_valid <= 1'b0;
    end else if (load) begin
      frm <= frame_in;
      len <= len_in;
      idx <= '0;
      out_valid <= 1'b1;
    end else if (out_valid && out_ready) begin
      if (idx == len - LW'(1)) out_valid <= 1'b0;
      else idx <= idx + LW'(1);
    end
  end
endmodule

// File: rtl/cmd_responder.sv
module cmd_responder
  import cmd_responder_pkg::*;
#(
  parameter int CLK_HZ = 50_000_000,
  parameter logic [31:0] UNIX_RESET = 32'd0,
  parameter int MAX_ARGS = 4,
  localparam int RESP_MAX = 3 + TIME_BYTES,
  localparam int CW = $clog2(MAX_ARGS + 2),
  localparam int LW = $clog2(RESP_MAX + 1)
) (
  input  logic clk,
  input  logic rst,
  input  logic in_valid,
  output logic in_ready,
  input  logic [7:0] in_data,
  input  logic in_last,
  output logic out_valid,
  input  logic out_ready,
  output logic [7:0] out_data,
  output logic out_last,
  output logic poll_en,
  output logic [7:0] poll_period,
  output logic [15:0] poll_mask,
  output logic poll_change,
  output logic pwr_off_req,
  output logic sys_rst_req
);
  logic pkt_valid;
  logic [7:0] pkt_cmd;
  logic [MAX_ARGS-1:0][7:0] pkt_args;
  logic [CW-1:0] pkt_nargs;
  logic [31:0] seconds;
  logic time_load;
  logic [31:0] time_val;
  logic [RESP_MAX-1:0][7:0] frame;
  logic [LW-1:0] frame_len;

  cmdrsp_rx #(.MAX_ARGS(MAX_ARGS)) u_rx (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_data(in_data),
    .in_last(in_last), .hold(out_valid), .in_ready(in_ready),
    .pkt_valid(pkt_valid), .pkt_cmd(pkt_cmd), .pkt_args(pkt_args),
    .pkt_nargs(pkt_nargs)
  );

  cmdrsp_rtc #(.CLK_HZ(CLK_HZ), .UNIX_RESET(UNIX_RESET)) u_rtc (
    .clk(clk), .rst(rst), .load(time_load), .load_val(time_val),
    .seconds(seconds)
  );

  cmdrsp_exec #(.MAX_ARGS(MAX_ARGS), .RESP_MAX(RESP_MAX)) u_exec (
    .clk(clk), .rst(rst), .go(pkt_valid), .cmd(pkt_cmd), .args(pkt_args),
    .nargs(pkt_nargs), .seconds(seconds), .frame(frame),
    .frame_len(frame_len), .time_load(time_load), .time_val(time_val),
    .poll_en(poll_en), .poll_period(poll_period), .poll_mask(poll_mask),
    .poll_change(poll_change), .pwr_off_req(pwr_off_req),
    .sys_rst_req(sys_rst_req)
  );

  cmdrsp_tx #(.RESP_MAX(RESP_MAX)) u_tx (
    .clk(clk), .rst(rst), .load(pkt_valid), .frame_in(frame),
    .len_in(frame_len), .out_ready(out_ready), .out_valid(out_valid),
    .out_data(out_data), .out_last(out_last)
  );
endmodule

// File: rtl/cmd_responder_chk.sv
module cmd_responder_chk (
  input logic clk,
  input logic rst,
  input logic in_ready,
  input logic out_valid,
  input logic out_ready,
  input logic [7:0] out_data,
  input logic out_last,
  input logic poll_en,
  input logic [7:0] poll_period,
  input logic poll_change,
  input logic pwr_off_req,
  input logic sys_rst_req
);
  // R1: response byte held under back-pressure
  p_hold_stable_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  // R1: no input taken while a reply is pending
  p_no_input_during_reply_r1: assert property (@(posedge clk) disable iff (rst)
    out_valid |-> !in_ready);

  // R2: a reply opens with either the command type or the error type
  p_first_byte_type_r2: assert property (@(posedge clk) disable iff (rst)
    out_valid && !$past(out_valid) |-> (out_data == 8'h01 || out_data == 8'h02));

  // R7: period never becomes zero
  p_period_nonzero_r7: assert property (@(posedge clk) disable iff (rst)
    poll_period != 8'd0);

  // R9: change pulse only with a real toggle of the enable
  p_change_toggles_r9: assert property (@(posedge clk) disable iff (rst)
    poll_change |-> poll_en != $past(poll_en));

  // R10: single-cycle request pulses
  p_off_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    pwr_off_req |=> !pwr_off_req);
  p_rst_pulse_r10: assert property (@(posedge clk) disable iff (rst)
    sys_rst_req |=> !sys_rst_req);
  p_req_exclusive_r10: assert property (@(posedge clk) disable iff (rst)
    !(pwr_off_req && sys_rst_req));
endmodule

bind cmd_responder cmd_responder_chk u_chk (
  .clk(clk), .rst(rst), .in_ready(in_ready), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .poll_en(poll_en), .poll_period(poll_period), .poll_change(poll_change),
  .pwr_off_req(pwr_off_req), .sys_rst_req(sys_rst_req)
);

// File: tb/cmd_responder_test.sv
module cmd_responder_test;
  localparam int CLK_PERIOD = 10;
  localparam int HZ = 50;
  localparam logic [31:0] UNIX_R = 32'd1000;
  localparam logic [31:0] BASE = UNIX_R + 32'd2082844800;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic in_valid = 1'b0, in_last = 1'b0, out_ready = 1'b0;
  logic [7:0] in_data = 8'h00;
  logic in_ready, out_valid, out_last, poll_en, poll_change, pwr_off_req, sys_rst_req;
  logic [7:0] out_data, poll_period;
  logic [15:0] poll_mask;

  cmd_responder #(.CLK_HZ(HZ), .UNIX_RESET(UNIX_R), .MAX_ARGS(4)) uut (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_data(in_data), .in_last(in_last), .out_valid(out_valid),
    .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
    .poll_en(poll_en), .poll_period(poll_period), .poll_mask(poll_mask),
    .poll_change(poll_change), .pwr_off_req(pwr_off_req), .sys_rst_req(sys_rst_req)
  );

  always #(CLK_PERIOD/2) clk = ~clk;

  int cyc = 0;
  always @(posedge clk) if (rst) cyc <= 0; else cyc <= cyc + 1;

  int cnt_off = 0, cnt_rst = 0, cnt_chg = 0;
  always @(negedge clk) if (!rst) begin
    if (pwr_off_req) cnt_off++;
    if (sys_rst_req) cnt_rst++;
    if (poll_change) cnt_chg++;
  end

  int n_chk = 0, n_fail = 0;
  logic [7:0] pkt [8];
  int pkt_n;
  logic [7:0] got [8];
  int got_n;
  logic [7:0] expf [8];
  int exp_n;
  logic [7:0] argv [5];
  int last_edge;
  bit stable_ok, inrdy_ok;

  // model state
  logic m_en = 1'b0;
  logic [7:0] m_period = 8'd20;
  logic [15:0] m_mask = 16'hFFFF;
  logic [31:0] m_tval = BASE;
  int m_tref = 0;
  int e_off = 0, e_rst = 0, e_chg = 0;
  string m_tag;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [31:0] g, input logic [31:0] e);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, g, e);
    end
  endtask

  task automatic send_pkt();
    for (int i = 0; i < pkt_n; i++) begin
      in_valid = 1'b1; in_data = pkt[i]; in_last = (i == pkt_n - 1);
      while (!in_ready) @(negedge clk);
      @(negedge clk);
    end
    in_valid = 1'b0; in_last = 1'b0;
    last_edge = cyc;
  endtask

  task automatic collect();
    logic prev_stall = 1'b0;
    logic [7:0] prev_d = 8'h00;
    logic prev_l = 1'b0;
    got_n = 0; stable_ok = 1'b1; inrdy_ok = 1'b1;
    for (int t = 0; t < 400; t++) begin
      out_ready = ($urandom % 10) < 7;
      if (out_valid && in_ready) inrdy_ok = 1'b0;
      if (prev_stall && (!out_valid || out_data != prev_d || out_last != prev_l)) stable_ok = 1'b0;
      prev_stall = out_valid && !out_ready;
      prev_d = out_data; prev_l = out_last;
      if (out_valid && out_ready) begin
        if (got_n < 8) got[got_n] = out_data;
        got_n++;
        if (out_last) begin
          @(negedge clk);
          break;
        end
      end
      @(negedge clk);
    end
    out_ready = 1'b0;
  endtask

  // expected reply and model update for a command packet
  task automatic model(input logic [7:0] c, input int na);
    bit bad = 0, unk = 0;
    case (c)
      8'h01: bad = (na != 1);
      8'h14: bad = (na != 1) || (argv[0] == 8'd0);
      8'h19: bad = (na != 2);
      8'h0A, 8'h11, 8'h03: bad = (na != 0);
      8'h09: bad = (na != 4);
      default: unk = 1;
    endcase
    if (unk || bad) begin
      expf[0] = 8'h02; expf[1] = unk ? 8'h02 : 8'h05; expf[2] = 8'h01; expf[3] = c;
      exp_n = 4; m_tag = unk ? "R4" : "R3";
      return;
    end
    expf[0] = 8'h01; expf[1] = 8'h00; expf[2] = c; exp_n = 3; m_tag = "R2";
    case (c)
      8'h01: begin
        if ((argv[0] != 0) != m_en) e_chg++;
        m_en = (argv[0] != 0); m_tag = "R9";
      end
      8'h14: begin m_period = argv[0]; m_tag = "R7"; end
      8'h19: begin m_mask = {argv[0], argv[1]}; m_tag = "R8"; end
      8'h0A: begin e_off++; m_tag = "R10"; end
      8'h11: begin e_rst++; m_tag = "R10"; end
      8'h03: begin
        logic [31:0] tv;
        tv = m_tval + 32'((last_edge - m_tref) / HZ);
        expf[3] = tv[31:24]; expf[4] = tv[23:16]; expf[5] = tv[15:8]; expf[6] = tv[7:0];
        exp_n = 7; m_tag = "R5";
      end
      8'h09: begin
        m_tval = {argv[0], argv[1], argv[2], argv[3]};
        m_tref = last_edge + 1; m_tag = "R6";
      end
      default: ;
    endcase
  endtask

  task automatic run_cmd(input logic [7:0] c, input int na);
    bit ok;
    pkt[0] = 8'h01; pkt[1] = c;
    for (int i = 0; i < na; i++) pkt[2 + i] = argv[i];
    pkt_n = 2 + na;
    send_pkt();
    model(c, na);
    collect();
    ok = (got_n == exp_n);
    for (int i = 0; i < exp_n && i < got_n; i++) if (got[i] !== expf[i]) ok = 0;
    chk(ok, m_tag, $sformatf("reply to cmd %h (len %0d, byte0 %h)", c, got_n, got[0]),
        {got[got_n > 4 ? 4 : 0], got[got_n > 5 ? 5 : 1], got[got_n > 6 ? 6 : 2], got[3]},
        {expf[exp_n > 4 ? 4 : 0], expf[exp_n > 5 ? 5 : 1], expf[exp_n > 6 ? 6 : 2], expf[3]});
    chk(stable_ok && inrdy_ok, "R1", "held reply / input blocked", {30'd0, stable_ok, inrdy_ok}, 32'd3);
    chk(poll_en == m_en && poll_period == m_period && poll_mask == m_mask, "R9_R7_R8",
        "poll state", {7'd0, poll_en, poll_period, poll_mask}, {7'd0, m_en, m_period, m_mask});
    chk(cnt_off == e_off && cnt_rst == e_rst, "R10", "request pulses",
        32'(cnt_off * 256 + cnt_rst), 32'(e_off * 256 + e_rst));
    chk(cnt_chg == e_chg, "R9", "poll_change pulses", 32'(cnt_chg), 32'(e_chg));
  endtask

  task automatic run_silent(input string what);
    bit seen = 0;
    send_pkt();
    out_ready = 1'b1;
    for (int t = 0; t < 15; t++) begin
      @(negedge clk);
      if (out_valid) seen = 1;
    end
    out_ready = 1'b0;
    chk(!seen && in_ready && poll_mask == m_mask && poll_period == m_period && poll_en == m_en,
        "R11", what, {31'd0, seen}, 32'd0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end

  initial begin
    void'($urandom(32'd20240611));
    repeat (3) @(negedge clk);
    rst = 1'b0;
    // reset state
    chk(!out_valid && in_ready, "R1", "idle handshake", {30'd0, out_valid, in_ready}, 32'd1);
    chk(poll_period == 8'd20, "R7", "default period", 32'(poll_period), 32'd20);
    chk(poll_mask == 16'hFFFF, "R8", "default mask", 32'(poll_mask), 32'hFFFF);
    chk(poll_en == 1'b0, "R9", "default enable", 32'(poll_en), 32'd0);

    // R5: time after reset and after some seconds
    run_cmd(8'h03, 0);
    repeat (137) @(negedge clk);
    run_cmd(8'h03, 0);
    // R6: write then read
    argv[0] = 8'h12; argv[1] = 8'h34; argv[2] = 8'h56; argv[3] = 8'h78;
    run_cmd(8'h09, 4);
    run_cmd(8'h03, 0);
    repeat (75) @(negedge clk);
    run_cmd(8'h03, 0);
    argv[0] = 8'hFF; argv[1] = 8'hFF; argv[2] = 8'hFF; argv[3] = 8'hFF;
    run_cmd(8'h09, 4);
    repeat (60) @(negedge clk);
    run_cmd(8'h03, 0);
    // R7: zero period rejected
    argv[0] = 8'd0; run_cmd(8'h14, 1);
    argv[0] = 8'd7; run_cmd(8'h14, 1);
    // R8
    argv[0] = 8'hA5; argv[1] = 8'h3C; run_cmd(8'h19, 2);
    // R9: enable, same again, disable
    argv[0] = 8'h80; run_cmd(8'h01, 1);
    argv[0] = 8'h01; run_cmd(8'h01, 1);
    argv[0] = 8'h00; run_cmd(8'h01, 1);
    // R10
    run_cmd(8'h0A, 0);
    run_cmd(8'h11, 0);
    // R3: wrong counts, including saturated five-argument packet
    run_cmd(8'h0A, 1);
    argv[4] = 8'h99; run_cmd(8'h09, 5);
    run_cmd(8'h19, 1);
    // R4
    run_cmd(8'h55, 0);
    run_cmd(8'h00, 2);
    // R11
    pkt[0] = 8'h03; pkt[1] = 8'h19; pkt[2] = 8'h00; pkt[3] = 8'h00; pkt_n = 4;
    run_silent("timer-type packet dropped");
    pkt[0] = 8'h01; pkt_n = 1;
    run_silent("one-byte packet dropped");
    run_cmd(8'h03, 0);

    // constrained random mix
    for (int it = 0; it < 60; it++) begin
      logic [7:0] c;
      int na, pick;
      logic [7:0] ops [8];
      ops[0] = 8'h01; ops[1] = 8'h03; ops[2] = 8'h09; ops[3] = 8'h0A;
      ops[4] = 8'h11; ops[5] = 8'h14; ops[6] = 8'h19; ops[7] = 8'($urandom);
      pick = $urandom % 8; c = ops[pick];
      case (c)
        8'h01, 8'h14: na = 1;
        8'h19: na = 2;
        8'h09: na = 4;
        default: na = 0;
      endcase
      if (($urandom % 10) < 3) na = $urandom % 6;
      for (int i = 0; i < 5; i++) argv[i] = 8'($urandom);
      if (($urandom % 4) == 0) argv[0] = 8'd0;
      repeat ($urandom % 40) @(negedge clk);
      run_cmd(c, na);
    end

    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule